// File: doc/BRIEF.md
# Target State Capture and Restore Sequencer

This block sits between a debug host and a small 8-bit target processor whose instruction clock it owns and whose program data bus it can overdrive. Once the host has stopped the target, a capture run records the target's architectural state. The program counter is read straight off the address bus. Registers that have no read path are recovered by injecting short instruction sequences that copy each value into Y and then jump through Y. The copied value then appears on the high byte of the program address, where the block samples it. The X index is found by zero-filling zero page, storing a marker through X, and scanning zero page for the marker.

A restore run puts that state back so that the target continues where it stopped. It writes the saved zero-page image back byte by byte and reloads the accumulator. It then jumps to one address before the saved program counter and reloads Y with a final injected load that also steps the counter onto the saved address. X and the output registers are never disturbed. The host starts each run with a one-cycle request. It reads the captured values from the output ports after the completion pulse.

Top module: `tgt_state_seq`

## Requirements
- R1: While reset is asserted and after it is released, with no request, `tgt_clk`, `inj_en`, `busy` and `done` are all low.
- R2: On a capture request, `cap_pc` takes the value on `tgt_addr` in the cycle the request is seen, before the first target clock pulse.
- R3: Injected instructions use these `inj_op` codes, with the operand on `inj_arg`: 0x00 no-op, 0x10 Y←arg, 0x11 AC←arg, 0x12 Y←AC, 0x13 Y←IN, 0x14 Y←mem[arg], 0x20 mem[arg]←AC, 0x21 mem[X]←AC, 0x30 jump to {Y,arg}. The target latches each word on a rising `tgt_clk` and executes it on the next rising edge, so a jump has one delay slot. Y, AC and the input register are captured in that order, each from the high address byte after a jump through Y followed by a no-op.
- R4: All 256 zero-page bytes are captured in ascending order before any of them is overwritten, and a restore writes back exactly the captured image.
- R5: After a capture, the target's zero page holds 0 everywhere except 1 at index X, and `cap_x` equals the target's X.
- R6: A capture issues exactly 1038 + 3·X target clock pulses, for X from 0 to 255.
- R7: After a restore, the target's AC and Y equal the captured values, its program counter equals `cap_pc`, and its X is unchanged.
- R8: The jump target used by a restore is `cap_pc` minus one, modulo 2^16, so a saved program counter of 0x0000 is restored correctly.
- R9: Each injected word is held for the whole of its pulse, and `tgt_clk` is low for `HALF_CYC` cycles and then high for `HALF_CYC` cycles.
- R10: A capture or restore request that arrives while a run is in progress is ignored and does not change the result.
- R11: `done` is high for exactly one cycle when a run ends, and `busy` is low in that cycle.
- R12: A restore issues exactly 517 target clock pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cap_req | input | 1 | Start a capture run (one cycle) |
| rest_req | input | 1 | Start a restore run (one cycle) |
| tgt_addr | input | 16 | Target program address bus |
| tgt_clk | output | 1 | Clock driven into the target |
| inj_en | output | 1 | Overdrive the target's program data bus |
| inj_op | output | 8 | Injected opcode byte |
| inj_arg | output | 8 | Injected operand byte |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse when a run ends |
| cap_pc | output | 16 | Captured program counter |
| cap_y | output | 8 | Captured Y register |
| cap_ac | output | 8 | Captured accumulator |
| cap_in | output | 8 | Captured input register |
| cap_x | output | 8 | Captured X index |

## Verification
The assertions check on every cycle the pulse shape: the high phase never ends before the slot ends, and the clock stays idle outside a run. They also check that the injected word stays stable inside a slot, that `done` is a single-cycle pulse with `busy` low, and that the saved program counter never moves during a run. The ordering of the injections, the values recovered through the address high byte, the search for X, the pulse counts and the restored zero page cannot be checked cycle by cycle. They are shown only by the bench's scenarios, which run a behavioural target beside the block and use X values at both ends of the range and a saved program counter of zero.

// File: rtl/tss_pkg.sv
package tss_pkg;

  localparam int OP_W = 8;

  // target instruction codes used by the injector
  localparam logic [OP_W-1:0] OP_NOP    = 8'h00;
  localparam logic [OP_W-1:0] OP_LDI_Y  = 8'h10;
  localparam logic [OP_W-1:0] OP_LDI_AC = 8'h11;
  localparam logic [OP_W-1:0] OP_AC_Y   = 8'h12;
  localparam logic [OP_W-1:0] OP_IN_Y   = 8'h13;
  localparam logic [OP_W-1:0] OP_ZP_Y   = 8'h14;
  localparam logic [OP_W-1:0] OP_ST_ZP  = 8'h20;
  localparam logic [OP_W-1:0] OP_ST_X   = 8'h21;
  localparam logic [OP_W-1:0] OP_JMP_Y  = 8'h30;

  typedef enum logic [3:0] {
    S_IDLE,
    S_RD_Y,
    S_RD_AC,
    S_RD_IN,
    S_RD_ZP,
    S_CLR_AC,
    S_CLR_ZP,
    S_MARK,
    S_SCAN,
    S_WB_ZP,
    S_TAIL
  } seq_state_e;

  // index of the final injection slot in each phase
  function automatic logic [2:0] last_step(seq_state_e s);
    case (s)
      S_RD_Y:   return 3'd1;
      S_RD_AC:  return 3'd2;
      S_RD_IN:  return 3'd2;
      S_RD_ZP:  return 3'd2;
      S_SCAN:   return 3'd2;
      S_MARK:   return 3'd1;
      S_WB_ZP:  return 3'd1;
      S_TAIL:   return 3'd4;
      default:  return 3'd0;
    endcase
  endfunction

endpackage

// File: rtl/tss_pulse_gen.sv
module tss_pulse_gen #(
  parameter int HALF_CYC = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tgt_clk,
  output logic slot_end
);

  localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam logic [CW-1:0] CMAX = CW'(HALF_CYC - 1);

  logic          ph_q, ph_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          wrap;

  assign wrap = (cnt_q == CMAX);

  always_comb begin
    ph_d  = ph_q;
    cnt_d = cnt_q;
    if (!run) begin
      ph_d  = 1'b0;
      cnt_d = '0;
    end else if (wrap) begin
      ph_d  = ~ph_q;
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= 1'b0;
      cnt_q <= '0;
    end else begin
      ph_q  <= ph_d;
      cnt_q <= cnt_d;
    end
  end

  assign tgt_clk  = ph_q;
  assign slot_end = run & ph_q & wrap;

  // R9
  hi_phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt_clk && !slot_end) |=> tgt_clk);

  // R9
  slot_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slot_end |=> !tgt_clk);

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !tgt_clk);

endmodule

// File: rtl/tss_zp_store.sv
module tss_zp_store #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [DATA_W-1:0] idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  localparam int DEPTH = 1 << DATA_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[idx] <= wdata;
    end
  end

  assign rdata = mem[idx];

endmodule

// File: rtl/tss_inject_sel.sv
module tss_inject_sel
  import tss_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  seq_state_e          st,
  input  logic [2:0]          step,
  input  logic [DATA_W-1:0]   idx,
  input  logic [DATA_W-1:0]   zp_byte,
  input  logic [DATA_W-1:0]   sv_ac,
  input  logic [DATA_W-1:0]   sv_y,
  input  logic [2*DATA_W-1:0] pc_m1,
  output logic [OP_W-1:0]     op,
  output logic [DATA_W-1:0]   arg
);

  always_comb begin
    op  = OP_NOP;
    arg = '0;
    case (st)
      S_RD_Y: begin
        if (step == 3'd0) op = OP_JMP_Y;
      end
      S_RD_AC, S_RD_IN, S_RD_ZP, S_SCAN: begin
        case (step)
          3'd0: begin
            if (st == S_RD_AC)      op = OP_AC_Y;
            else if (st == S_RD_IN) op = OP_IN_Y;
            else begin
              op  = OP_ZP_Y;
              arg = idx;
            end
          end
          3'd1:    op = OP_JMP_Y;
          default: op = OP_NOP;
        endcase
      end
      S_CLR_AC: begin
        op = OP_LDI_AC;
      end
      S_CLR_ZP: begin
        op  = OP_ST_ZP;
        arg = idx;
      end
      S_MARK: begin
        if (step == 3'd0) begin
          op  = OP_LDI_AC;
          arg = DATA_W'(1);
        end else begin
          op = OP_ST_X;
        end
      end
      S_WB_ZP: begin
        if (step == 3'd0) begin
          op  = OP_LDI_AC;
          arg = zp_byte;
        end else begin
          op  = OP_ST_ZP;
          arg = idx;
        end
      end
      S_TAIL: begin
        case (step)
          3'd0: begin op = OP_LDI_AC; arg = sv_ac; end
          3'd1: begin op = OP_LDI_Y;  arg = pc_m1[2*DATA_W-1 -: DATA_W]; end
          3'd2: begin op = OP_JMP_Y;  arg = pc_m1[DATA_W-1:0]; end
          3'd3: begin op = OP_LDI_Y;  arg = sv_y; end
          default: op = OP_NOP;
        endcase
      end
      default: begin
        op  = OP_NOP;
        arg = '0;
      end
    endcase
  end

endmodule

// File: rtl/tgt_state_seq.sv
module tgt_state_seq
  import tss_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int HALF_CYC = 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cap_req,
  input  logic                rest_req,
  input  logic [2*DATA_W-1:0] tgt_addr,
  output logic                tgt_clk,
  output logic                inj_en,
  output logic [OP_W-1:0]     inj_op,
  output logic [DATA_W-1:0]   inj_arg,
  output logic                busy,
  output logic                done,
  output logic [2*DATA_W-1:0] cap_pc,
  output logic [DATA_W-1:0]   cap_y,
  output logic [DATA_W-1:0]   cap_ac,
  output logic [DATA_W-1:0]   cap_in,
  output logic [DATA_W-1:0]   cap_x
);

  localparam int AW = 2 * DATA_W;

  // reset: asserted at once, released on the clock
  logic [1:0] rs_q;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_n_s = rs_q[1];

  seq_state_e        st_q, st_d;
  logic [2:0]        step_q, step_d;
  logic [DATA_W-1:0] idx_q, idx_d;
  logic              done_q, done_d;

  logic pc_en, y_en, ac_en, in_en, x_en, zp_we;
  logic slot_end, last, idx_max, scan_hit, run;
  logic [DATA_W-1:0] addr_hi, zp_byte;
  logic [AW-1:0]     pc_m1;

  assign addr_hi  = tgt_addr[AW-1 -: DATA_W];
  assign run      = (st_q != S_IDLE);
  assign last     = (step_q == last_step(st_q));
  assign idx_max  = (idx_q == {DATA_W{1'b1}});
  assign scan_hit = (addr_hi == DATA_W'(1));
  assign pc_m1    = cap_pc - AW'(1);

  always_comb begin
    st_d   = st_q;
    step_d = step_q;
    idx_d  = idx_q;
    done_d = 1'b0;
    pc_en  = 1'b0;
    y_en   = 1'b0;
    ac_en  = 1'b0;
    in_en  = 1'b0;
    x_en   = 1'b0;
    zp_we  = 1'b0;
    if (st_q == S_IDLE) begin
      if (cap_req) begin
        st_d   = S_RD_Y;
        step_d = 3'd0;
        idx_d  = '0;
        pc_en  = 1'b1;
      end else if (rest_req) begin
        st_d   = S_WB_ZP;
        step_d = 3'd0;
        idx_d  = '0;
      end
    end else if (slot_end) begin
      if (!last) begin
        step_d = step_q + 3'd1;
      end else begin
        step_d = 3'd0;
        case (st_q)
          S_RD_Y:  begin y_en  = 1'b1; st_d = S_RD_AC; end
          S_RD_AC: begin ac_en = 1'b1; st_d = S_RD_IN; end
          S_RD_IN: begin in_en = 1'b1; st_d = S_RD_ZP; end
          S_RD_ZP: begin
            zp_we = 1'b1;
            if (idx_max) begin st_d = S_CLR_AC; idx_d = '0; end
            else         idx_d = idx_q + DATA_W'(1);
          end
          S_CLR_AC: st_d = S_CLR_ZP;
          S_CLR_ZP: begin
            if (idx_max) begin st_d = S_MARK; idx_d = '0; end
            else         idx_d = idx_q + DATA_W'(1);
          end
          S_MARK: st_d = S_SCAN;
          S_SCAN: begin
            if (scan_hit || idx_max) begin
              x_en   = 1'b1;
              st_d   = S_IDLE;
              done_d = 1'b1;
            end else begin
              idx_d = idx_q + DATA_W'(1);
            end
          end
          S_WB_ZP: begin
            if (idx_max) begin st_d = S_TAIL; idx_d = '0; end
            else         idx_d = idx_q + DATA_W'(1);
          end
          S_TAIL: begin
            st_d   = S_IDLE;
            done_d = 1'b1;
          end
          default: st_d = S_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      st_q   <= S_IDLE;
      step_q <= 3'd0;
      idx_q  <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      step_q <= step_d;
      idx_q  <= idx_d;
      done_q <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      cap_pc <= '0;
      cap_y  <= '0;
      cap_ac <= '0;
      cap_in <= '0;
      cap_x  <= '0;
    end else begin
      if (pc_en) cap_pc <= tgt_addr;
      if (y_en)  cap_y  <= addr_hi;
      if (ac_en) cap_ac <= addr_hi;
      if (in_en) cap_in <= addr_hi;
      if (x_en)  cap_x  <= idx_q;
    end
  end

  tss_pulse_gen #(.HALF_CYC(HALF_CYC)) u_pulse (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .run      (run),
    .tgt_clk  (tgt_clk),
    .slot_end (slot_end)
  );

  tss_zp_store #(.DATA_W(DATA_W)) u_zp (
    .clk   (clk),
    .we    (zp_we),
    .idx   (idx_q),
    .wdata (addr_hi),
    .rdata (zp_byte)
  );

  tss_inject_sel #(.DATA_W(DATA_W)) u_sel (
    .st      (st_q),
    .step    (step_q),
    .idx     (idx_q),
    .zp_byte (zp_byte),
    .sv_ac   (cap_ac),
    .sv_y    (cap_y),
    .pc_m1   (pc_m1),
    .op      (inj_op),
    .arg     (inj_arg)
  );

  assign inj_en = run;
  assign busy   = run;
  assign done   = done_q;

  // R9
  inj_hold_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (busy && !slot_end) |=> (busy && $stable({inj_op, inj_arg})));

  // R11
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    done |=> !done);

  // R11
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    done |-> !busy);

  // R10
  pc_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    busy |=> $stable(cap_pc));

endmodule

// File: tb/tgt_state_seq_bench.sv
module tgt_state_seq_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cap_req, rest_req;
  logic [15:0] tgt_addr;
  logic        tgt_clk, inj_en, busy, done;
  logic [7:0]  inj_op, inj_arg;
  logic [15:0] cap_pc;
  logic [7:0]  cap_y, cap_ac, cap_in, cap_x;

  always #4 clk = ~clk;

  tgt_state_seq u_tgt_state_seq (
    .clk(clk), .rst_n(rst_n), .cap_req(cap_req), .rest_req(rest_req),
    .tgt_addr(tgt_addr), .tgt_clk(tgt_clk), .inj_en(inj_en),
    .inj_op(inj_op), .inj_arg(inj_arg), .busy(busy), .done(done),
    .cap_pc(cap_pc), .cap_y(cap_y), .cap_ac(cap_ac), .cap_in(cap_in),
    .cap_x(cap_x)
  );

  // behavioural target: latch on one edge, execute on the next
  logic [15:0] m_pc, npc;
  logic [7:0]  m_y, m_ac, m_in, m_x, m_irop, m_irarg;
  logic [7:0]  m_zp [256];
  int          pulses = 0;

  assign tgt_addr = m_pc;

  always @(posedge tgt_clk) begin
    if (inj_en) begin
      npc = m_pc + 16'd1;
      case (m_irop)
        8'h10: m_y = m_irarg;
        8'h11: m_ac = m_irarg;
        8'h12: m_y = m_ac;
        8'h13: m_y = m_in;
        8'h14: m_y = m_zp[m_irarg];
        8'h20: m_zp[m_irarg] = m_ac;
        8'h21: m_zp[m_x] = m_ac;
        8'h30: npc = {m_y, m_irarg};
        default: ;
      endcase
      m_pc    = npc;
      m_irop  = inj_op;
      m_irarg = inj_arg;
      pulses  = pulses + 1;
    end
  end

  int tests = 0;
  int fails = 0;
  int cyc   = 0;

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (cyc > 150000) begin
      tests = tests + 1;
      fails = fails + 1;
      $display("FAIL watchdog: act=%0d cycles exp<=150000", cyc);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests = tests + 1;
    if (act !== exp) begin
      fails = fails + 1;
      $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // pc, y, ac, in, x, seed
  localparam logic [55:0] VEC [5] = '{
    {16'h1234, 8'h56, 8'h9A, 8'hBC, 8'h00, 8'h11},
    {16'h0000, 8'hFF, 8'h00, 8'h01, 8'hFF, 8'h37},
    {16'hFFFF, 8'h00, 8'hFF, 8'h7E, 8'h80, 8'h5A},
    {16'h8001, 8'h01, 8'h01, 8'h00, 8'h01, 8'h00},
    {16'h00FF, 8'hA5, 8'h3C, 8'hC3, 8'hFE, 8'hE1}
  };

  function automatic logic [7:0] pat(input int i, input logic [7:0] seed);
    return 8'(i * 7) + seed;
  endfunction

  task automatic load_target(input logic [55:0] v);
    m_pc = v[55:40]; m_y = v[39:32]; m_ac = v[31:24];
    m_in = v[23:16]; m_x = v[15:8];
    m_irop = 8'h00; m_irarg = 8'h00;
    for (int i = 0; i < 256; i++) m_zp[i] = pat(i, v[7:0]);
  endtask

  task automatic wait_done;
    while (done !== 1'b1) @(negedge clk);
    chk("R11 busy low with done", {31'd0, busy}, 32'd0);
    @(negedge clk);
    chk("R11 done one cycle", {31'd0, done}, 32'd0);
  endtask

  task automatic run_capture(input logic [15:0] exp_pc);
    @(negedge clk) cap_req = 1'b1;
    @(negedge clk) cap_req = 1'b0;
    chk("R2 pc before pulses", {16'd0, cap_pc}, {16'd0, exp_pc});
    wait_done();
  endtask

  task automatic run_restore;
    @(negedge clk) rest_req = 1'b1;
    @(negedge clk) rest_req = 1'b0;
    wait_done();
  endtask

  initial begin
    int p0, bad;
    logic [55:0] v;
    rst_n = 1'b0; cap_req = 1'b0; rest_req = 1'b0;
    load_target(VEC[0]);
    repeat (3) @(negedge clk);
    // R1 during reset
    chk("R1 tgt_clk in reset", {31'd0, tgt_clk}, 32'd0);
    chk("R1 inj_en in reset", {31'd0, inj_en}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 idle busy/done/clk", {29'd0, busy, done, tgt_clk}, 32'd0);

    for (int k = 0; k < 5; k++) begin
      v = VEC[k];
      load_target(v);
      p0 = pulses;
      run_capture(v[55:40]);
      chk("R2 cap_pc", {16'd0, cap_pc}, {16'd0, v[55:40]});
      chk("R3 cap_y", {24'd0, cap_y}, {24'd0, v[39:32]});
      chk("R3 cap_ac", {24'd0, cap_ac}, {24'd0, v[31:24]});
      chk("R3 cap_in", {24'd0, cap_in}, {24'd0, v[23:16]});
      chk("R5 cap_x", {24'd0, cap_x}, {24'd0, v[15:8]});
      chk("R6 capture pulses", pulses - p0, 1038 + 3 * int'(v[15:8]));
      bad = 0;
      for (int i = 0; i < 256; i++)
        if (m_zp[i] !== ((i == int'(v[15:8])) ? 8'd1 : 8'd0)) bad++;
      chk("R5 zero page marked", bad, 0);
      m_ac = ~v[31:24];
      m_y  = ~v[39:32];
      p0 = pulses;
      run_restore();
      chk("R12 restore pulses", pulses - p0, 517);
      chk(v[55:40] == 16'h0000 ? "R8 pc wrap" : "R7 pc", {16'd0, m_pc}, {16'd0, v[55:40]});
      chk("R7 ac", {24'd0, m_ac}, {24'd0, v[31:24]});
      chk("R7 y", {24'd0, m_y}, {24'd0, v[39:32]});
      chk("R7 x untouched", {24'd0, m_x}, {24'd0, v[15:8]});
      bad = 0;
      for (int i = 0; i < 256; i++)
        if (m_zp[i] !== pat(i, v[7:0])) bad++;
      chk("R4 zero page restored", bad, 0);
    end

    // R10: requests during a capture are ignored
    v = VEC[2];
    load_target(v);
    p0 = pulses;
    @(negedge clk) cap_req = 1'b1;
    @(negedge clk) cap_req = 1'b0;
    repeat (100) @(negedge clk);
    rest_req = 1'b1; cap_req = 1'b1;
    @(negedge clk) rest_req = 1'b0; cap_req = 1'b0;
    chk("R10 still busy", {31'd0, busy}, 32'd1);
    wait_done();
    chk("R10 pulses unchanged", pulses - p0, 1038 + 3 * int'(v[15:8]));
    chk("R10 cap_pc kept", {16'd0, cap_pc}, {16'd0, v[55:40]});
    chk("R10 cap_x", {24'd0, cap_x}, {24'd0, v[15:8]});
    repeat (3) @(negedge clk);
    chk("R1 quiet after run", {29'd0, busy, done, tgt_clk}, 32'd0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule